// File: doc/BRIEF.md
# Flash Command Register Window

This block is the device-side register file of a nonvolatile memory that software drives entirely through a small memory-mapped window. The host has a synchronous port with a byte-offset address and a 16-bit data bus. Through it the host reads identification and query words. It stages a command code, a 32-bit target address, a 32-bit data count and a data word, and then starts the command with a separate write to an execute register. No command takes effect on the write that stages it.

A simulated command engine runs each launched command. Programs and erases keep the device busy for a parameter-set number of cycles, and that count freezes while the operation is suspended. Lock, unlock, lock-status, query and OTP-read commands finish in a single cycle. Before a program or erase starts, the engine checks the target block against a per-block lock table and checks the supply-low input. A command that fails any check changes no state. It finishes in one cycle and reports its cause in the status word.

The status word mixes bits that track live state with error bits that clear when the host reads them. An error pin is high whenever any error bit is set. A small program buffer sits in the top of the window, and the host can read it, write it, and clear all of it with one write.

Top module: `fcw_top`

## Requirements
- R1: Reads return 0x0050, 0x0046, 0x004F and 0x0057 at offsets 0x00, 0x02, 0x04 and 0x06. Offset 0x20 returns MFR_ID and 0x22 returns DEV_ID. Offset 0x40 returns BUF_BASE and 0x42 returns BUF_WORDS. An offset with no register reads 0. Read data appears on `hostRdata` on the clock edge that samples `hostRd`.
- R2: The staging registers read back what was written: code at 0x80, data at 0x84, address low/high at 0x88/0x8A, and count low/high at 0x90/0x92. The target block is bits [BLK_LSB +: log2(NUM_BLOCKS)] of {high, low} (by default, bits 3:0 of the address high register).
- R3: A command starts only on a write of 0x0001 to 0xC0 while the device is ready and not suspended, and only if the staged code is one of 0x41, 0xE9, 0xC0, 0x20, 0x61, 0x62, 0x65, 0x98 or 0x97. Any other execute write is ignored.
- R4: A program (0x41, 0xE9, 0xC0) or erase (0x20) that passes its checks holds ready (status bit 7) low for exactly BUSY_CYCLES cycles. Reads sampled on the 1st through BUSY_CYCLES-th edge after the execute edge show busy.
- R5: Lock (0x61) sets and unlock (0x62) clears the lock bit of the target block. Lock status (0x65) sets status bit 1 if the target block is locked. These commands, query (0x98) and OTP read (0x97) are busy for one cycle.
- R6: A program or erase aimed at a locked block changes no lock or buffer state. After one busy cycle it sets bit 1 plus bit 4 (program) or bit 5 (erase).
- R7: With `vppLow` high at launch, a program or erase on an unlocked block sets bit 3 plus bit 4 or bit 5, after one busy cycle.
- R8: A word program (0x41) with address bit 0 set sets bits 9:8 to 2'b11 plus bit 4. A buffered program (0xE9) whose count exceeds BUF_WORDS sets bit 12 plus bit 4.
- R9: Writing 0x0001 to 0xC8 during a multi-cycle program or erase suspends it. Bit 2 (program) or bit 6 (erase) is set, ready reads 1, and the busy count freezes. While suspended, the only accepted execute is code 0xD0, which clears the flag and runs the remaining cycles. A suspend write while idle is ignored.
- R10: The status register is at 0xCC. Reading it clears bits 1, 3, 4, 5, 9:8 and 12. Bits 2, 6 and 7 follow the engine, and bit 15 always reads 1. The reset value is 0x8080.
- R11: `errOut` is high exactly when the status word ANDed with 0x133A is non-zero.
- R12: Buffer word i is read and written at BUF_BASE + 2*i. Writing 0x0001 to 0xC4 zeroes the whole buffer. A write of any other value to 0xC4 or 0xC8 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hostWr | input | 1 | Host write strobe |
| hostRd | input | 1 | Host read strobe |
| hostAddr | input | ADDR_W | Byte offset into the window |
| hostWdata | input | 16 | Write data |
| vppLow | input | 1 | Programming supply is low |
| hostRdata | output | 16 | Read data, registered |
| errOut | output | 1 | Any error bit set in the status word |

## Verification
Read data is due on the edge that samples the read strobe. A scoreboard queues each expected word when the read is driven and compares it one half-cycle after that edge. Taking the execute edge as E, a one-cycle command still shows busy at E+1 and shows its result at E+2. A multi-cycle command shows busy through E+BUSY_CYCLES and shows ready at E+BUSY_CYCLES+1, so the bench places reads on both sides of that boundary. Around a suspend, the bench counts the busy edges before the suspend and after the resume, and expects ready exactly when the total reaches BUSY_CYCLES.

// File: rtl/fcw_pkg.sv
package fcw_pkg;

  // window offsets (byte addresses)
  localparam logic [7:0] OFF_Q0      = 8'h00;
  localparam logic [7:0] OFF_Q1      = 8'h02;
  localparam logic [7:0] OFF_Q2      = 8'h04;
  localparam logic [7:0] OFF_Q3      = 8'h06;
  localparam logic [7:0] OFF_MFR     = 8'h20;
  localparam logic [7:0] OFF_DEV     = 8'h22;
  localparam logic [7:0] OFF_BUFLOC  = 8'h40;
  localparam logic [7:0] OFF_BUFLEN  = 8'h42;
  localparam logic [7:0] OFF_CODE    = 8'h80;
  localparam logic [7:0] OFF_DATA    = 8'h84;
  localparam logic [7:0] OFF_ADDRLO  = 8'h88;
  localparam logic [7:0] OFF_ADDRHI  = 8'h8A;
  localparam logic [7:0] OFF_CNTLO   = 8'h90;
  localparam logic [7:0] OFF_CNTHI   = 8'h92;
  localparam logic [7:0] OFF_EXEC    = 8'hC0;
  localparam logic [7:0] OFF_BUFCLR  = 8'hC4;
  localparam logic [7:0] OFF_SUSP    = 8'hC8;
  localparam logic [7:0] OFF_STATUS  = 8'hCC;

  // command codes
  localparam logic [15:0] CMD_WPROG   = 16'h0041;
  localparam logic [15:0] CMD_BPROG   = 16'h00E9;
  localparam logic [15:0] CMD_ERASE   = 16'h0020;
  localparam logic [15:0] CMD_LOCK    = 16'h0061;
  localparam logic [15:0] CMD_UNLOCK  = 16'h0062;
  localparam logic [15:0] CMD_LKSTAT  = 16'h0065;
  localparam logic [15:0] CMD_QUERY   = 16'h0098;
  localparam logic [15:0] CMD_OTPRD   = 16'h0097;
  localparam logic [15:0] CMD_OTPPRG  = 16'h00C0;
  localparam logic [15:0] CMD_RESUME  = 16'h00D0;

  localparam logic [15:0] GO_VALUE    = 16'h0001;

  // status bit positions
  localparam int ST_LOCKED = 1;
  localparam int ST_PSUSP  = 2;
  localparam int ST_VPP    = 3;
  localparam int ST_PERR   = 4;
  localparam int ST_EERR   = 5;
  localparam int ST_ESUSP  = 6;
  localparam int ST_READY  = 7;
  localparam int ST_REG0   = 8;
  localparam int ST_REG1   = 9;
  localparam int ST_AO     = 12;
  localparam int ST_AVAIL  = 15;

  // error mask; identical to the set of clear-on-read bits
  localparam logic [15:0] ERR_MASK = 16'h133A;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_BUSY = 2'd1,
    ENG_SUSP = 2'd2
  } engState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic        lockSet;
    logic        lockClr;
    logic [15:0] statSet;
    logic        ready;
    logic        progSusp;
    logic        eraseSusp;
  } engCtl_t;

endpackage

// File: rtl/fcw_engine.sv
module fcw_engine
  import fcw_pkg::*;
#(
  parameter int BUSY_CYCLES = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        exeReq,
  input  logic        suspReq,
  input  logic [15:0] cmdCode,
  input  logic        tgtLocked,
  input  logic        addrOdd,
  input  logic        countTooBig,
  input  logic        vppLow,
  output engCtl_t     eng
);

  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LONG_LOAD = CNT_W'(BUSY_CYCLES - 1);

  engState_t        state;
  logic [CNT_W-1:0] cnt;
  logic [15:0]      pendSet;
  logic             pendLock;
  logic             pendUnlock;
  logic             opErase;
  logic             progSusp;
  logic             eraseSusp;

  // launch decode
  logic        lOk;
  logic        lLong;
  logic        lErase;
  logic        lLock;
  logic        lUnlock;
  logic [15:0] lSet;

  always_comb begin
    lOk     = 1'b1;
    lLong   = 1'b0;
    lErase  = 1'b0;
    lLock   = 1'b0;
    lUnlock = 1'b0;
    lSet    = '0;
    case (cmdCode)
      CMD_WPROG, CMD_BPROG, CMD_OTPPRG: begin
        if (tgtLocked) begin
          lSet[ST_LOCKED] = 1'b1;
          lSet[ST_PERR]   = 1'b1;
        end else if (vppLow) begin
          lSet[ST_VPP]    = 1'b1;
          lSet[ST_PERR]   = 1'b1;
        end else if (cmdCode == CMD_WPROG && addrOdd) begin
          lSet[ST_REG0]   = 1'b1;
          lSet[ST_REG1]   = 1'b1;
          lSet[ST_PERR]   = 1'b1;
        end else if (cmdCode == CMD_BPROG && countTooBig) begin
          lSet[ST_AO]     = 1'b1;
          lSet[ST_PERR]   = 1'b1;
        end else begin
          lLong = 1'b1;
        end
      end
      CMD_ERASE: begin
        if (tgtLocked) begin
          lSet[ST_LOCKED] = 1'b1;
          lSet[ST_EERR]   = 1'b1;
        end else if (vppLow) begin
          lSet[ST_VPP]    = 1'b1;
          lSet[ST_EERR]   = 1'b1;
        end else begin
          lLong  = 1'b1;
          lErase = 1'b1;
        end
      end
      CMD_LOCK:   lLock   = 1'b1;
      CMD_UNLOCK: lUnlock = 1'b1;
      CMD_LKSTAT: lSet[ST_LOCKED] = tgtLocked;
      CMD_QUERY, CMD_OTPRD: lOk = 1'b1;
      default:    lOk = 1'b0;
    endcase
  end

  wire doneNow = (state == ENG_BUSY) && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ENG_IDLE;
      cnt        <= '0;
      pendSet    <= '0;
      pendLock   <= 1'b0;
      pendUnlock <= 1'b0;
      opErase    <= 1'b0;
      progSusp   <= 1'b0;
      eraseSusp  <= 1'b0;
    end else begin
      case (state)
        ENG_IDLE: begin
          if (exeReq && lOk) begin
            state      <= ENG_BUSY;
            cnt        <= lLong ? LONG_LOAD : '0;
            pendSet    <= lSet;
            pendLock   <= lLock;
            pendUnlock <= lUnlock;
            opErase    <= lErase;
          end
        end
        ENG_BUSY: begin
          if (cnt == '0) begin
            state <= ENG_IDLE;
          end else begin
            cnt <= cnt - CNT_W'(1);
            if (suspReq) begin
              state <= ENG_SUSP;
              if (opErase) eraseSusp <= 1'b1;
              else         progSusp  <= 1'b1;
            end
          end
        end
        ENG_SUSP: begin
          if (exeReq && cmdCode == CMD_RESUME) begin
            state     <= ENG_BUSY;
            progSusp  <= 1'b0;
            eraseSusp <= 1'b0;
          end
        end
        default: state <= ENG_IDLE;
      endcase
    end
  end

  always_comb begin
    eng.lockSet   = doneNow && pendLock;
    eng.lockClr   = doneNow && pendUnlock;
    eng.statSet   = doneNow ? pendSet : '0;
    eng.ready     = (state != ENG_BUSY);
    eng.progSusp  = progSusp;
    eng.eraseSusp = eraseSusp;
  end

endmodule

// File: rtl/fcw_regs.sv
module fcw_regs
  import fcw_pkg::*;
#(
  parameter int                ADDR_W     = 8,
  parameter int                BUF_WORDS  = 16,
  parameter logic [ADDR_W-1:0] BUF_BASE   = 8'hE0,
  parameter int                NUM_BLOCKS = 16,
  parameter int                BLK_LSB    = 16,
  parameter logic [15:0]       MFR_ID     = 16'h0089,
  parameter logic [15:0]       DEV_ID     = 16'h4A21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWdata,
  output logic [15:0]       hostRdata,
  output logic              errOut,
  input  engCtl_t           eng,
  output logic [15:0]       cmdCode,
  output logic              tgtLocked,
  output logic              addrOdd,
  output logic              countTooBig,
  output logic              exeReq,
  output logic              suspReq,
  output logic [15:0]       statusWord
);

  localparam int BIDX_W = $clog2(BUF_WORDS);
  localparam int LIDX_W = $clog2(NUM_BLOCKS);
  localparam int HI_LSB = BLK_LSB - 16;
  localparam logic [ADDR_W-1:0] BUF_SPAN = ADDR_W'(2 * BUF_WORDS);

  logic [15:0] dataR, addrLoR, addrHiR, cntLoR, cntHiR;
  logic [15:0] bufMem [BUF_WORDS];
  logic [NUM_BLOCKS-1:0] lockBits;
  logic [15:0] rcBits;
  logic [15:0] rdMux;

  // decode
  logic [ADDR_W-1:0] bufOff;
  logic [BIDX_W-1:0] bufIdx;
  logic              bufHit;
  logic              bufClr;
  logic              statRd;
  logic [LIDX_W-1:0] lockIdx;

  always_comb begin
    bufOff  = hostAddr - BUF_BASE;
    bufIdx  = bufOff[BIDX_W:1];
    bufHit  = (hostAddr >= BUF_BASE) && (bufOff < BUF_SPAN) && !hostAddr[0];
    exeReq  = hostWr && (hostAddr == ADDR_W'(OFF_EXEC))   && (hostWdata == GO_VALUE);
    bufClr  = hostWr && (hostAddr == ADDR_W'(OFF_BUFCLR)) && (hostWdata == GO_VALUE);
    suspReq = hostWr && (hostAddr == ADDR_W'(OFF_SUSP))   && (hostWdata == GO_VALUE);
    statRd  = hostRd && (hostAddr == ADDR_W'(OFF_STATUS));
    lockIdx = addrHiR[HI_LSB +: LIDX_W];
  end

  // staging registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmdCode <= '0;
      dataR   <= '0;
      addrLoR <= '0;
      addrHiR <= '0;
      cntLoR  <= '0;
      cntHiR  <= '0;
    end else if (hostWr) begin
      case (hostAddr)
        ADDR_W'(OFF_CODE):   cmdCode <= hostWdata;
        ADDR_W'(OFF_DATA):   dataR   <= hostWdata;
        ADDR_W'(OFF_ADDRLO): addrLoR <= hostWdata;
        ADDR_W'(OFF_ADDRHI): addrHiR <= hostWdata;
        ADDR_W'(OFF_CNTLO):  cntLoR  <= hostWdata;
        ADDR_W'(OFF_CNTHI):  cntHiR  <= hostWdata;
        default: ;
      endcase
    end
  end

  // program buffer
  always_ff @(posedge clk) begin
    if (!rst_n || bufClr) begin
      for (int i = 0; i < BUF_WORDS; i++) bufMem[i] <= '0;
    end else if (hostWr && bufHit) begin
      bufMem[bufIdx] <= hostWdata;
    end
  end

  // lock table, one flop per block
  for (genvar b = 0; b < NUM_BLOCKS; b++) begin : g_lock
    logic lockQ;
    always_ff @(posedge clk) begin
      if (!rst_n)
        lockQ <= 1'b0;
      else if (eng.lockSet && lockIdx == LIDX_W'(b))
        lockQ <= 1'b1;
      else if (eng.lockClr && lockIdx == LIDX_W'(b))
        lockQ <= 1'b0;
    end
    assign lockBits[b] = lockQ;
  end

  assign tgtLocked   = lockBits[lockIdx];
  assign addrOdd     = addrLoR[0];
  assign countTooBig = {cntHiR, cntLoR} > 32'(BUF_WORDS);

  // status word: clear-on-read error bits plus live engine bits
  always_ff @(posedge clk) begin
    if (!rst_n)
      rcBits <= '0;
    else
      rcBits <= ((statRd ? 16'h0000 : rcBits) | eng.statSet) & ERR_MASK;
  end

  always_comb begin
    statusWord            = rcBits;
    statusWord[ST_PSUSP]  = eng.progSusp;
    statusWord[ST_ESUSP]  = eng.eraseSusp;
    statusWord[ST_READY]  = eng.ready;
    statusWord[ST_AVAIL]  = 1'b1;
  end

  assign errOut = |(statusWord & ERR_MASK);

  // read mux
  always_comb begin
    case (hostAddr)
      ADDR_W'(OFF_Q0):     rdMux = 16'h0050;
      ADDR_W'(OFF_Q1):     rdMux = 16'h0046;
      ADDR_W'(OFF_Q2):     rdMux = 16'h004F;
      ADDR_W'(OFF_Q3):     rdMux = 16'h0057;
      ADDR_W'(OFF_MFR):    rdMux = MFR_ID;
      ADDR_W'(OFF_DEV):    rdMux = DEV_ID;
      ADDR_W'(OFF_BUFLOC): rdMux = 16'(BUF_BASE);
      ADDR_W'(OFF_BUFLEN): rdMux = 16'(BUF_WORDS);
      ADDR_W'(OFF_CODE):   rdMux = cmdCode;
      ADDR_W'(OFF_DATA):   rdMux = dataR;
      ADDR_W'(OFF_ADDRLO): rdMux = addrLoR;
      ADDR_W'(OFF_ADDRHI): rdMux = addrHiR;
      ADDR_W'(OFF_CNTLO):  rdMux = cntLoR;
      ADDR_W'(OFF_CNTHI):  rdMux = cntHiR;
      ADDR_W'(OFF_STATUS): rdMux = statusWord;
      default:             rdMux = bufHit ? bufMem[bufIdx] : 16'h0000;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      hostRdata <= '0;
    else if (hostRd)
      hostRdata <= rdMux;
  end

endmodule

// File: rtl/fcw_top.sv
module fcw_top
  import fcw_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter int                BUF_WORDS   = 16,
  parameter logic [ADDR_W-1:0] BUF_BASE    = 8'hE0,
  parameter int                NUM_BLOCKS  = 16,
  parameter int                BLK_LSB     = 16,
  parameter int                BUSY_CYCLES = 8,
  parameter logic [15:0]       MFR_ID      = 16'h0089,
  parameter logic [15:0]       DEV_ID      = 16'h4A21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hostWr,
  input  logic              hostRd,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [15:0]       hostWdata,
  input  logic              vppLow,
  output logic [15:0]       hostRdata,
  output logic              errOut
);

  engCtl_t     eng;
  logic [15:0] cmdCode;
  logic        tgtLocked;
  logic        addrOdd;
  logic        countTooBig;
  logic        exeReq;
  logic        suspReq;
  logic [15:0] statusWord;
  logic        readyNow;

  assign readyNow = eng.ready;

  fcw_regs #(
    .ADDR_W    (ADDR_W),
    .BUF_WORDS (BUF_WORDS),
    .BUF_BASE  (BUF_BASE),
    .NUM_BLOCKS(NUM_BLOCKS),
    .BLK_LSB   (BLK_LSB),
    .MFR_ID    (MFR_ID),
    .DEV_ID    (DEV_ID)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .hostWr     (hostWr),
    .hostRd     (hostRd),
    .hostAddr   (hostAddr),
    .hostWdata  (hostWdata),
    .hostRdata  (hostRdata),
    .errOut     (errOut),
    .eng        (eng),
    .cmdCode    (cmdCode),
    .tgtLocked  (tgtLocked),
    .addrOdd    (addrOdd),
    .countTooBig(countTooBig),
    .exeReq     (exeReq),
    .suspReq    (suspReq),
    .statusWord (statusWord)
  );

  fcw_engine #(
    .BUSY_CYCLES(BUSY_CYCLES)
  ) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .exeReq     (exeReq),
    .suspReq    (suspReq),
    .cmdCode    (cmdCode),
    .tgtLocked  (tgtLocked),
    .addrOdd    (addrOdd),
    .countTooBig(countTooBig),
    .vppLow     (vppLow),
    .eng        (eng)
  );

endmodule

// File: rtl/fcw_checker.sv
module fcw_checker
  import fcw_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hostWr,
  input logic              hostRd,
  input logic [ADDR_W-1:0] hostAddr,
  input logic [15:0]       hostWdata,
  input logic [15:0]       hostRdata,
  input logic              errOut,
  input logic [15:0]       statusWord,
  input logic              readyNow
);

  wire statRead = hostRd && (hostAddr == ADDR_W'(OFF_STATUS));
  wire suspNow  = statusWord[ST_PSUSP] || statusWord[ST_ESUSP];

  AST_STATUS_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
    statRead |=> hostRdata == $past(statusWord)); // R10

  AST_IDLE_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (statRead && readyNow) |=> !errOut); // R10

  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(errOut) |-> $rose(readyNow)); // R6

  AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    suspNow |-> readyNow); // R9

  AST_SUSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({statusWord[ST_PSUSP], statusWord[ST_ESUSP]})); // R9

  AST_BAD_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWr && hostAddr == ADDR_W'(OFF_EXEC) && hostWdata != GO_VALUE && readyNow && !suspNow)
      |=> readyNow); // R3

endmodule

bind fcw_top fcw_checker #(.ADDR_W(ADDR_W)) u_fcw_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .hostWr    (hostWr),
  .hostRd    (hostRd),
  .hostAddr  (hostAddr),
  .hostWdata (hostWdata),
  .hostRdata (hostRdata),
  .errOut    (errOut),
  .statusWord(statusWord),
  .readyNow  (readyNow)
);

// File: tb/fcw_top_bench.sv
`timescale 1ns/1ps
module fcw_top_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hostWr = 1'b0;
  logic        hostRd = 1'b0;
  logic [7:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic        vppLow = 1'b0;
  logic [15:0] hostRdata;
  logic        errOut;

  int nChk = 0;
  int nErr = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];
  logic        rdSeen = 1'b0;

  always #2 clk = ~clk;

  fcw_top u_fcw_top (
    .clk      (clk),
    .rst_n    (rst_n),
    .hostWr   (hostWr),
    .hostRd   (hostRd),
    .hostAddr (hostAddr),
    .hostWdata(hostWdata),
    .vppLow   (vppLow),
    .hostRdata(hostRdata),
    .errOut   (errOut)
  );

  // monitor: a read strobe sampled at an edge has its data due on that edge
  always @(posedge clk) rdSeen <= hostRd && rst_n;

  always @(negedge clk) begin
    if (rdSeen && expQ.size() > 0) begin
      logic [15:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      nChk++;
      if (hostRdata !== e) begin
        nErr++;
        $display("FAIL %s: got %h expected %h", t, hostRdata, e);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    hostWr = 1'b1; hostAddr = a; hostWdata = d;
    @(negedge clk);
    hostWr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] e, input string t);
    hostRd = 1'b1; hostAddr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    hostRd = 1'b0;
  endtask

  task automatic chkErr(input logic e, input string t);
    nChk++;
    if (errOut !== e) begin
      nErr++;
      $display("FAIL %s: errOut got %b expected %b", t, errOut, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic stage(input logic [15:0] code, input logic [15:0] hi, input logic [15:0] lo);
    wr(8'h80, code);
    wr(8'h8A, hi);
    wr(8'h88, lo);
  endtask

  task automatic go();
    wr(8'hC0, 16'h0001);
  endtask

  // short command: busy at E+1, result at E+2
  task automatic shortCmd(input logic [15:0] code, input logic [15:0] lo,
                          input logic [15:0] res, input string t);
    stage(code, 16'h0003, lo);
    go();
    rd(8'hCC, 16'h8000, t);
    rd(8'hCC, res, t);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    rd(8'hCC, 16'h8080, "R10 reset status");
    chkErr(1'b0, "R11 reset");

    // R1 identification and query
    rd(8'h00, 16'h0050, "R1 query P");
    rd(8'h02, 16'h0046, "R1 query F");
    rd(8'h04, 16'h004F, "R1 query O");
    rd(8'h06, 16'h0057, "R1 query W");
    rd(8'h20, 16'h0089, "R1 manufacturer");
    rd(8'h22, 16'h4A21, "R1 device");
    rd(8'h40, 16'h00E0, "R1 buffer location");
    rd(8'h42, 16'h0010, "R1 buffer size");
    rd(8'h30, 16'h0000, "R1 undefined offset");

    // R2 staging readback
    wr(8'h84, 16'hA5A5);
    rd(8'h84, 16'hA5A5, "R2 data reg");
    wr(8'h90, 16'h0005);
    wr(8'h92, 16'h0001);
    rd(8'h90, 16'h0005, "R2 count low");
    rd(8'h92, 16'h0001, "R2 count high");
    stage(16'h0098, 16'h1234, 16'h5678);
    rd(8'h8A, 16'h1234, "R2 address high");
    rd(8'h88, 16'h5678, "R2 address low");
    rd(8'h80, 16'h0098, "R2 code reg");

    // R12 buffer
    wr(8'hE4, 16'hBEEF);
    wr(8'hFE, 16'h1111);
    rd(8'hE4, 16'hBEEF, "R12 buffer word 2");
    rd(8'hFE, 16'h1111, "R12 buffer last word");
    wr(8'hC4, 16'h0002);
    rd(8'hE4, 16'hBEEF, "R12 clear with wrong value ignored");
    wr(8'hC4, 16'h0001);
    rd(8'hE4, 16'h0000, "R12 buffer cleared");
    rd(8'hFE, 16'h0000, "R12 last word cleared");

    // R3 ignored executes
    stage(16'h0055, 16'h0003, 16'h0010);
    go();
    rd(8'hCC, 16'h8080, "R3 unknown code ignored");
    stage(16'h0041, 16'h0003, 16'h0010);
    wr(8'hC0, 16'h0002);
    rd(8'hCC, 16'h8080, "R3 wrong execute value ignored");
    wr(8'hC8, 16'h0001);
    rd(8'hCC, 16'h8080, "R9 suspend while idle ignored");

    // R4 long program, with an execute during busy (R3)
    go();                                     // E
    rd(8'hCC, 16'h8000, "R4 busy at first edge");   // E+1
    wr(8'h80, 16'h0061);                      // E+2
    go();                                     // E+3, ignored
    idle(4);                                  // E+4..E+7
    rd(8'hCC, 16'h8000, "R4 busy at last edge");    // E+8
    rd(8'hCC, 16'h8080, "R4 ready after window");   // E+9
    shortCmd(16'h0065, 16'h0010, 16'h8080, "R3 lock during busy ignored");

    // R5 lock and lock status
    shortCmd(16'h0061, 16'h0000, 16'h8080, "R5 lock one cycle");
    stage(16'h0065, 16'h0003, 16'h0000);
    go();
    rd(8'hCC, 16'h8000, "R5 lock status busy");
    chkErr(1'b1, "R11 error pin on locked flag");
    rd(8'hCC, 16'h8082, "R5 lock status reports locked");
    chkErr(1'b0, "R10 error cleared by read");
    rd(8'hCC, 16'h8080, "R10 clear-on-read");

    // R6 locked target
    shortCmd(16'h0041, 16'h0010, 16'h8092, "R6 program to locked block");
    shortCmd(16'h0020, 16'h0000, 16'h80A2, "R6 erase to locked block");
    shortCmd(16'h0065, 16'h0000, 16'h8082, "R6 lock state unchanged");
    shortCmd(16'h0062, 16'h0000, 16'h8080, "R5 unlock");
    shortCmd(16'h0065, 16'h0000, 16'h8080, "R5 unlocked status");

    // R7 supply low
    vppLow = 1'b1;
    shortCmd(16'h0041, 16'h0010, 16'h8098, "R7 program with supply low");
    chkErr(1'b0, "R11 cleared after read");
    shortCmd(16'h0020, 16'h0000, 16'h80A8, "R7 erase with supply low");
    vppLow = 1'b0;

    // R8 region and overflow
    shortCmd(16'h0041, 16'h0011, 16'h8390, "R8 odd word program");
    wr(8'h90, 16'h0011);
    wr(8'h92, 16'h0000);
    shortCmd(16'h00E9, 16'h0000, 16'h9090, "R8 buffer count overflow");
    wr(8'h90, 16'h0010);
    go();                                      // E
    rd(8'hCC, 16'h8000, "R8 count at limit busy");
    idle(6);
    rd(8'hCC, 16'h8000, "R4 buffered program last busy");
    rd(8'hCC, 16'h8080, "R4 buffered program done");

    // R9 erase suspend / resume
    stage(16'h0020, 16'h0003, 16'h0000);
    go();                                      // E
    rd(8'hCC, 16'h8000, "R9 erase busy");       // E+1
    wr(8'hC8, 16'h0001);                       // E+2
    rd(8'hCC, 16'h80C0, "R9 erase suspended");
    idle(5);
    rd(8'hCC, 16'h80C0, "R9 still suspended");
    wr(8'h80, 16'h0061);
    go();
    rd(8'hCC, 16'h80C0, "R9 other execute ignored while suspended");
    wr(8'h80, 16'h00D0);
    go();                                      // R
    rd(8'hCC, 16'h8000, "R9 resumed busy");    // R+1
    idle(4);                                   // R+2..R+5
    rd(8'hCC, 16'h8000, "R9 erase remaining busy"); // R+6
    rd(8'hCC, 16'h8080, "R9 erase complete");  // R+7
    shortCmd(16'h0065, 16'h0000, 16'h8080, "R9 lock while suspended ignored");

    // R9 program suspend / resume
    stage(16'h0041, 16'h0003, 16'h0010);
    go();                                      // E
    wr(8'hC8, 16'h0001);                       // E+1
    rd(8'hCC, 16'h8084, "R9 program suspended");
    wr(8'h80, 16'h00D0);
    go();                                      // R
    rd(8'hCC, 16'h8000, "R9 program resumed"); // R+1
    idle(5);                                   // R+2..R+6
    rd(8'hCC, 16'h8000, "R9 program remaining busy"); // R+7
    rd(8'hCC, 16'h8080, "R9 program complete");       // R+8

    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nErr++;
      nChk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", nErr, nChk);
      $finish;
    end
  end

endmodule